// File: doc/BRIEF.md
# Oversampled DAC Serial Frame Transmitter

This block turns a stream of parallel two's complement audio samples into the three-wire serial stream that a sign-magnitude current-output DAC expects: a bit clock, a data line and a word-latch line. It is placed after an oversampling interpolation filter and runs at the oversampled rate. Every sample becomes one fixed frame of 32 bit-clock periods. The data word sits at the end of the frame, most significant bit first, and the bits before it are zero. The bit clock is an even integer divide of the system clock.

Samples arrive through a valid/ready handshake. The block takes one sample per frame, in the last system cycle of each frame. If no sample is offered at that moment, the previous sample is sent again, so the converter never sees a gap. A mode input picks a 24-bit payload or a 20-bit payload. In 20-bit mode the 20 upper bits of the sample are sent. The word latch falls on the bit-clock falling edge right after the last data bit has been clocked in. It stays low for two full bit periods, so it is still low across the first rising edge of the next frame.

Top module: `dac_frame_tx`

## Requirements
- R1: While `rstN` is low, `bitClk`, `serData`, `wordLatch` and `sampleReady` are all 0.
- R2: `bitClk` is continuous with a period of `CLK_DIV` system clocks. It is low for the first `CLK_DIV/2` cycles of each bit slot and high for the rest.
- R3: A frame is 32 bit slots. `serData` changes only where `bitClk` falls or at a slot start, and it is stable while `bitClk` is high.
- R4: With `wordMode20`=0 captured, slots 0..7 carry 0 and slots 8..31 carry sample bits 23 down to 0, in that order.
- R5: With `wordMode20`=1 captured, slots 0..11 carry 0 and slots 12..31 carry sample bits 23 down to 4, in that order.
- R6: `wordLatch` falls at the same system edge where `bitClk` falls at the end of slot 31. It is low during slots 0 and 1, so it is low at the first rising `bitClk` edge of the frame. It rises at the start of slot 2.
- R7: `sampleReady` is 1 for exactly one system cycle per frame, the last cycle of slot 31. A sample with `sampleValid`=1 in that cycle is sent in the frame that follows.
- R8: If `sampleValid` is 0 in the ready cycle, the next frame repeats the last accepted sample. `sampleData` and `sampleValid` have no effect in any other cycle.
- R9: `wordMode20` is sampled only in the ready cycle. Changing it during a frame does not alter the frame in progress.
- R10: The first frame after reset carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleData | input | SAMPLE_W | Two's complement sample |
| sampleValid | input | 1 | Sample offered |
| sampleReady | output | 1 | Sample taken this cycle (one cycle per frame) |
| wordMode20 | input | 1 | 1 selects the 20-bit payload, 0 the 24-bit payload |
| bitClk | output | 1 | Serial bit clock |
| serData | output | 1 | Serial data, MSB first |
| wordLatch | output | 1 | Word latch; the falling edge loads the word |

## Verification
A wrong phase or slot counter shows up within one bit period. It appears as a `bitClk` edge in the wrong system cycle, or as a latch edge or ready pulse in the wrong slot. A wrong hold register or framing shows up on `serData` at the first payload slot of the next frame, which is at most 32 bit periods later. The reference model tracks the accepted word and mode frame by frame, so any bit placed in the wrong slot is found in that same cycle.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

  // Strobes from the frame timer to the datapath, valid for one system cycle.
  typedef struct packed {
    logic rise;   // bit clock goes high at the next edge
    logic shift;  // bit clock goes low, next bit of the current frame
    logic load;   // bit clock goes low, new frame starts
  } serStrobe_t;

endpackage

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dac_frame_pkg::*;
#(
  parameter int FRAME_BITS      = 32,
  parameter int CLK_DIV         = 4,
  parameter int LATCH_LOW_SLOTS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  output serStrobe_t strb,
  output logic       sampleReady,
  output logic       wordLatch
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int PH_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int SLOT_W = $clog2(FRAME_BITS);

  logic [PH_W-1:0]   phaseCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic phaseLast, slotLast, riseNow, latchRise;

  always_comb begin
    phaseLast = (phaseCnt == PH_W'(CLK_DIV - 1));
    slotLast  = (slotCnt == SLOT_W'(FRAME_BITS - 1));
    riseNow   = (phaseCnt == PH_W'(HALF - 1));
    latchRise = phaseLast && (slotCnt == SLOT_W'(LATCH_LOW_SLOTS - 1));
    strb.rise  = riseNow;
    strb.shift = phaseLast && !slotLast;
    strb.load  = phaseLast && slotLast;
    sampleReady = strb.load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      slotCnt  <= '0;
    end else if (phaseLast) begin
      phaseCnt <= '0;
      slotCnt  <= slotLast ? '0 : slotCnt + 1'b1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordLatch <= 1'b0;
    end else if (strb.load) begin
      wordLatch <= 1'b0;
    end else if (latchRise) begin
      wordLatch <= 1'b1;
    end
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady); // R7

  AST_LATCH_LOW_FIRST_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rise && slotCnt == '0) |=> !wordLatch); // R6

endmodule

// File: rtl/dac_frame_dp.sv
module dac_frame_dp
  import dac_frame_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int SHORT_W    = 20,
  parameter int FRAME_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  serStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  input  logic                wordMode20,
  output logic                bitClk,
  output logic                serData
);

  logic [SAMPLE_W-1:0]   holdReg;
  logic [SAMPLE_W-1:0]   nextWord;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] framedLong;
  logic [FRAME_BITS-1:0] framedShort;

  always_comb begin
    nextWord    = sampleValid ? sampleData : holdReg;
    framedLong  = FRAME_BITS'(nextWord);
    framedShort = FRAME_BITS'(nextWord[SAMPLE_W-1 -: SHORT_W]);
    serData     = shiftReg[FRAME_BITS-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strb.load && sampleValid) begin
      holdReg <= sampleData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= wordMode20 ? framedShort : framedLong;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClk <= 1'b0;
    end else if (strb.rise) begin
      bitClk <= 1'b1;
    end else if (strb.shift || strb.load) begin
      bitClk <= 1'b0;
    end
  end

  AST_STEP_ONLY_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift || strb.load) |-> bitClk); // R2

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (bitClk && $past(bitClk)) |-> $stable(serData)); // R3

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int SAMPLE_W        = 24,
  parameter int SHORT_W         = 20,
  parameter int FRAME_BITS      = 32,
  parameter int CLK_DIV         = 4,
  parameter int LATCH_LOW_SLOTS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic                wordMode20,
  output logic                bitClk,
  output logic                serData,
  output logic                wordLatch
);

  serStrobe_t strb;

  dac_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .CLK_DIV(CLK_DIV), .LATCH_LOW_SLOTS(LATCH_LOW_SLOTS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sampleReady(sampleReady), .wordLatch(wordLatch)
  );

  dac_frame_dp #(
    .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .FRAME_BITS(FRAME_BITS)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sampleData(sampleData), .sampleValid(sampleValid), .wordMode20(wordMode20),
    .bitClk(bitClk), .serData(serData)
  );

  AST_LATCH_FALLS_WITH_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordLatch) |-> $fell(bitClk)); // R6

endmodule

// File: tb/tb_dac_frame_tx.sv
module tb_dac_frame_tx;

  localparam int W = 24, SW = 20, F = 32, DIV = 4, NFR = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] sampleData = '0;
  logic sampleValid = 1'b0, wordMode20 = 1'b0;
  logic sampleReady, bitClk, serData, wordLatch;

  int nTests = 0, nFail = 0;
  bit done = 0;

  logic [W-1:0] dataTab [NFR];
  bit validTab [NFR];
  bit modeTab [NFR];

  always #10 clk = ~clk;

  dac_frame_tx #(.SAMPLE_W(W), .SHORT_W(SW), .FRAME_BITS(F), .CLK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .wordMode20(wordMode20), .bitClk(bitClk),
    .serData(serData), .wordLatch(wordLatch));

  task automatic chk(string req, string what, logic act, logic exp, int cyc);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  initial begin
    logic [W-1:0] heldWord, curWord;
    bit curMode;
    string dTag;
    dataTab = '{24'h7FFFFF, 24'h800000, 24'h000000, 24'hFFFFFF, 24'h123456, 24'hA5C3F1,
                24'h7FFFFF, 24'h800001, 24'h0F0F0F, 24'h555555, 24'hC00003, 24'h3AAAAA,
                24'h000001, 24'h000000};
    validTab = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 0, 1, 1, 1, 1};
    modeTab  = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 0};
    heldWord = '0; curWord = '0; curMode = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "bitClk", bitClk, 1'b0, -1);
    chk("R1", "serData", serData, 1'b0, -1);
    chk("R1", "wordLatch", wordLatch, 1'b0, -1);
    chk("R1", "sampleReady", sampleReady, 1'b0, -1);
    rstN = 1'b1;

    for (int n = 0; n < NFR * F * DIV; n++) begin
      int fr, s, ph, w, idx;
      logic expBit;
      bit expReady;
      fr = n / (F * DIV);
      s  = (n / DIV) % F;
      ph = n % DIV;
      // stimulus: junk data except near the frame end, mode flipped mid-frame (R8, R9)
      sampleValid = validTab[fr];
      sampleData  = (s >= 30) ? dataTab[fr] : W'(n * 7919 + 12345);
      wordMode20  = (s >= 10 && s <= 20) ? !modeTab[fr] : modeTab[fr];
      // expectations
      w = curMode ? SW : W;
      if (s >= F - w) begin
        idx = W - 1 - (s - (F - w));
        expBit = curWord[idx];
      end else begin
        expBit = 1'b0;
      end
      expReady = (ph == DIV - 1) && (s == F - 1);
      if (fr == 0) dTag = "R10";
      else if (s >= 10 && s <= 20) dTag = "R9";
      else if (!validTab[fr - 1]) dTag = "R8";
      else if (ph >= DIV / 2) dTag = "R3";
      else if (curMode) dTag = "R5";
      else dTag = "R4";
      chk("R2", "bitClk", bitClk, (ph >= DIV / 2), n);
      chk(dTag, "serData", serData, expBit, n);
      chk("R6", "wordLatch", wordLatch, (s >= 2), n);
      chk("R7", "sampleReady", sampleReady, expReady, n);
      // model update for the coming edge
      if (expReady) begin
        if (sampleValid) heldWord = sampleData;
        curWord = heldWord;
        curMode = wordMode20;
      end
      @(negedge clk);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20 * 10000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule